// File: doc/BRIEF.md
# Nested Interrupt Acceptance Controller

This block decides, cycle by cycle, whether one of several pending interrupt requests is taken. A two-bit nesting level gates acceptance. At level 0 any request may be taken. At level 1 only the source named by a software-set priority register gets through. At levels 2 and 3 nothing is taken until a return lowers the level. Each acceptance raises the level by one. A one-cycle accept pulse reports the index of the granted source.

On every acceptance the block saves the level as it was before the increment, together with a few caller-supplied flag bits, into a small internal LIFO. A return strobe pops that word and restores the level, which models the save and restore of the processor status. While global enable is off, software can rewrite either level bit on its own. A handler uses this to drop the level back to 0, so that requests of lower priority can nest inside it.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, the level, global enable, priority register, accept, push, pop, status word and overflow flag are all 0, and the LIFO is empty.
- R2: When global enable is 1 and ret_i is 0, an eligible request is accepted. accept_o is high for exactly the cycle after the decision edge, and grant_idx_o carries the source index in that cycle.
- R3: Each acceptance raises level_o by exactly one, and the new value is visible in the same cycle as accept_o.
- R4: At level 1, only the source whose index is held in the priority register can be accepted.
- R5: At level 2 or 3, no request is accepted.
- R6: If the priority source is among the eligible requests, it wins. Otherwise the eligible source with the lowest index wins.
- R7: While global enable is 0, no request is accepted.
- R8: With each acceptance, push_o pulses together with accept_o. status_word_o then equals {flags_i, level before the increment}, with the level in bits [1:0]. status_word_o is 0 in any cycle with neither push_o nor pop_o.
- R9: A return strobe with a non-empty LIFO pops the newest word. In the next cycle, pop_o is 1, status_word_o shows the popped word, and level_o equals its bits [1:0]. No acceptance happens in the cycle of a return strobe.
- R10: A return strobe with an empty LIFO sets the level to 0 and leaves pop_o at 0.
- R11: Per-bit level writes (lvl_we_i[b] writes lvl_wd_i[b] into level bit b) take effect only while global enable is 0. They are ignored while it is 1, and a return strobe in the same cycle takes precedence over them.
- R12: The LIFO holds 4 words. An acceptance with a full LIFO drops the word, still raises the level, and sets ovf_o, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Request lines of the enabled sources |
| gie_we_i | input | 1 | Write strobe for global enable |
| gie_wd_i | input | 1 | New global enable value |
| prio_we_i | input | 1 | Write strobe for the priority register |
| prio_wd_i | input | IDX_W | Index of the highest-priority source |
| ret_i | input | 1 | Return-from-interrupt strobe |
| lvl_we_i | input | 2 | Per-bit write strobes for the level |
| lvl_wd_i | input | 2 | Per-bit write data for the level |
| flags_i | input | FLAG_W | Other status bits saved on acceptance |
| accept_o | output | 1 | One-cycle acceptance pulse |
| grant_idx_o | output | IDX_W | Index of the granted source |
| level_o | output | 2 | Current nesting level |
| push_o | output | 1 | A status word was saved |
| pop_o | output | 1 | A status word was restored |
| status_word_o | output | FLAG_W+2 | Saved or restored status word |
| ovf_o | output | 1 | Sticky LIFO overflow flag |

## Verification
Acceptance and return compete for the same cycle: requests stay high while ret_i pulses. The bench checks that the return wins, that accept_o stays low, and that the restored level is judged in the following cycle. A level write can also coincide with a return while global enable is off. Both collisions occur in directed steps and often in the random phase. Each cycle is compared against a bench model that applies the return first.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    LVL_OPEN  = 2'd0,
    LVL_PRIO  = 2'd1,
    LVL_HOLD2 = 2'd2,
    LVL_HOLD3 = 2'd3
  } lvl_e;
endpackage

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [IDX_W-1:0] prio_i,
  input  logic [1:0]       lvl_i,
  input  logic             allow_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC-1:0] prio_mask, elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_mask
    assign prio_mask[g] = (prio_i == IDX_W'(g));
  end

  always_comb begin
    unique case (lvl_e'(lvl_i))
      LVL_OPEN: elig = req_i;
      LVL_PRIO: elig = req_i & prio_mask;
      default:  elig = '0;
    endcase
    if (!allow_i) elig = '0;
  end

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = IDX_W'(i);
    end
    if (|(elig & prio_mask)) idx_o = prio_i;
  end

  assign valid_o = |elig;

  always_comb begin
    if (valid_o) begin
      a_r6_grant_is_requested: assert (req_i[idx_o]);
      a_r7_grant_allowed:      assert (allow_i);
    end
  end
endmodule

// File: rtl/nic_lifo.sv
module nic_lifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] rdata_o,
  output logic         ovf_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign rdata_o = empty_o ? '0 : mem_q[PTR_W'(cnt_q - 1'b1)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      if (full) begin
        ovf_o <= 1'b1;
      end else begin
        mem_q[PTR_W'(cnt_q)] <= wdata_i;
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r12_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r12_ovf_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !(push_i && full)) |=> !ovf_o);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int LIFO_DEPTH = 4,
  parameter int FLAG_W     = 2,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int WORD_W = FLAG_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              gie_we_i,
  input  logic              gie_wd_i,
  input  logic              prio_we_i,
  input  logic [IDX_W-1:0]  prio_wd_i,
  input  logic              ret_i,
  input  logic [1:0]        lvl_we_i,
  input  logic [1:0]        lvl_wd_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              accept_o,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic [1:0]        level_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [WORD_W-1:0] status_word_o,
  output logic              ovf_o
);
  logic              gie_q;
  logic [IDX_W-1:0]  prio_q;
  logic [1:0]        lvl_q;
  logic              arb_vld;
  logic [IDX_W-1:0]  arb_idx;
  logic              lifo_empty;
  logic [WORD_W-1:0] lifo_rdata, save_word;

  assign save_word = {flags_i, lvl_q};

  nic_arbiter #(.N_SRC(N_SRC)) u_arb (
    .req_i   (req_i),
    .prio_i  (prio_q),
    .lvl_i   (lvl_q),
    .allow_i (gie_q & ~ret_i),
    .valid_o (arb_vld),
    .idx_o   (arb_idx)
  );

  nic_lifo #(.DEPTH(LIFO_DEPTH), .W(WORD_W)) u_lifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (arb_vld),
    .wdata_i (save_word),
    .pop_i   (ret_i),
    .empty_o (lifo_empty),
    .rdata_o (lifo_rdata),
    .ovf_o   (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      prio_q <= '0;
    end else begin
      if (gie_we_i)  gie_q  <= gie_wd_i;
      if (prio_we_i) prio_q <= prio_wd_i;
    end
  end

  // level: accept > return > software bit writes (writes only with gie off)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_OPEN;
    end else if (arb_vld) begin
      lvl_q <= lvl_q + 2'd1;
    end else if (ret_i) begin
      lvl_q <= lifo_empty ? 2'd0 : lifo_rdata[1:0];
    end else if (!gie_q) begin
      for (int b = 0; b < 2; b++) begin
        if (lvl_we_i[b]) lvl_q[b] <= lvl_wd_i[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o      <= 1'b0;
      grant_idx_o   <= '0;
      push_o        <= 1'b0;
      pop_o         <= 1'b0;
      status_word_o <= '0;
    end else begin
      accept_o      <= arb_vld;
      grant_idx_o   <= arb_vld ? arb_idx : '0;
      push_o        <= arb_vld;
      pop_o         <= ret_i & ~lifo_empty;
      status_word_o <= arb_vld ? save_word
                     : (ret_i && !lifo_empty) ? lifo_rdata : '0;
    end
  end

  assign level_o = lvl_q;

  a_r3_level_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> level_o == $past(level_o) + 2'd1);
  a_r5_hold_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o[1] |=> !accept_o);
  a_r9_no_accept_on_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> !accept_o);
  a_r4_level1_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 2'd1) |=> (!accept_o || grant_idx_o == $past(prio_q)));
  a_r11_level_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_q && !ret_i && !arb_vld) |=> $stable(level_o));
  a_r7_gie_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |=> !accept_o);
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 8;
  localparam int DEPTH = 4;
  localparam int FLAG_W = 2;
  localparam int IDX_W = 3;
  localparam int WORD_W = FLAG_W + 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_SRC-1:0] req_i = '0;
  logic gie_we_i = 0, gie_wd_i = 0, prio_we_i = 0, ret_i = 0;
  logic [IDX_W-1:0] prio_wd_i = '0;
  logic [1:0] lvl_we_i = '0, lvl_wd_i = '0;
  logic [FLAG_W-1:0] flags_i = '0;
  logic accept_o, push_o, pop_o, ovf_o;
  logic [IDX_W-1:0] grant_idx_o;
  logic [1:0] level_o;
  logic [WORD_W-1:0] status_word_o;

  int tests = 0, errs = 0;

  // model state
  logic m_gie, m_acc, m_push, m_pop, m_ovf;
  logic [IDX_W-1:0] m_prio, m_idx;
  logic [1:0] m_lvl;
  logic [WORD_W-1:0] m_word;
  logic [WORD_W-1:0] m_stk [DEPTH];
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl #(.N_SRC(N_SRC), .LIFO_DEPTH(DEPTH), .FLAG_W(FLAG_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .gie_we_i(gie_we_i),
    .gie_wd_i(gie_wd_i), .prio_we_i(prio_we_i), .prio_wd_i(prio_wd_i),
    .ret_i(ret_i), .lvl_we_i(lvl_we_i), .lvl_wd_i(lvl_wd_i), .flags_i(flags_i),
    .accept_o(accept_o), .grant_idx_o(grant_idx_o), .level_o(level_o),
    .push_o(push_o), .pop_o(pop_o), .status_word_o(status_word_o), .ovf_o(ovf_o)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [IDX_W-1:0] pick(logic [N_SRC-1:0] e, logic [IDX_W-1:0] p);
    if (e[p]) return p;
    for (int i = 0; i < N_SRC; i++) if (e[i]) return IDX_W'(i);
    return '0;
  endfunction

  task automatic compare_all();
    chk("R2 accept", int'(accept_o), int'(m_acc));
    chk("R6 grant_idx", int'(grant_idx_o), int'(m_idx));
    chk("R3 level", int'(level_o), int'(m_lvl));
    chk("R8 push", int'(push_o), int'(m_push));
    chk("R9 pop", int'(pop_o), int'(m_pop));
    chk("R8 status_word", int'(status_word_o), int'(m_word));
    chk("R12 ovf", int'(ovf_o), int'(m_ovf));
  endtask

  // inputs already driven; advance model by one edge, then compare at next negedge
  task automatic tick();
    logic [N_SRC-1:0] elig;
    logic allow;
    allow = m_gie && !ret_i;
    elig = (m_lvl == 2'd0) ? req_i :
           (m_lvl == 2'd1) ? (req_i & (N_SRC'(1) << m_prio)) : '0;
    if (!allow) elig = '0;
    m_acc = |elig; m_push = m_acc; m_pop = 1'b0; m_word = '0;
    m_idx = m_acc ? pick(elig, m_prio) : '0;
    if (m_acc) begin
      m_word = {flags_i, m_lvl};
      if (m_cnt < DEPTH) begin m_stk[m_cnt] = m_word; m_cnt++; end
      else m_ovf = 1'b1;
      m_lvl = m_lvl + 2'd1;
    end else if (ret_i) begin
      if (m_cnt > 0) begin
        m_cnt--; m_word = m_stk[m_cnt]; m_lvl = m_word[1:0]; m_pop = 1'b1;
      end else m_lvl = 2'd0;
    end else if (!m_gie) begin
      for (int b = 0; b < 2; b++) if (lvl_we_i[b]) m_lvl[b] = lvl_wd_i[b];
    end
    if (gie_we_i) m_gie = gie_wd_i;
    if (prio_we_i) m_prio = prio_wd_i;
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(logic [N_SRC-1:0] rq, logic rt, logic gwe, logic gwd,
                       logic pwe, logic [IDX_W-1:0] pwd, logic [1:0] lwe,
                       logic [1:0] lwd, logic [FLAG_W-1:0] fl);
    req_i = rq; ret_i = rt; gie_we_i = gwe; gie_wd_i = gwd; prio_we_i = pwe;
    prio_wd_i = pwd; lvl_we_i = lwe; lvl_wd_i = lwd; flags_i = fl;
    tick();
  endtask

  task automatic idle(); drive('0, 0, 0, 0, 0, '0, '0, '0, '0); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_gie = 0; m_acc = 0; m_push = 0; m_pop = 0; m_ovf = 0;
    m_prio = '0; m_idx = '0; m_lvl = '0; m_word = '0; m_cnt = 0;
    for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 level", int'(level_o), 0);
    chk("R1 accept", int'(accept_o), 0);
    chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 word", int'(status_word_o), 0);
    // R1 empty LIFO: return gives no pop
    drive('0, 1, 0, 0, 0, '0, '0, '0, '0);
    chk("R1 lifo empty", int'(pop_o), 0);
    // R1 gie off after reset: a request is not taken
    drive(8'h01, 0, 0, 0, 0, '0, '0, '0, '0);
    chk("R1 gie cleared", int'(accept_o), 0);

    // enable, priority = 5
    drive('0, 0, 1, 1, 1, 3'd5, '0, '0, '0);
    // R6: sources 3 and 5 pending at level 0, priority 5 wins
    drive(8'h28, 0, 0, 0, 0, '0, '0, '0, 2'b10);
    chk("R6 prio wins", int'(grant_idx_o), 5);
    chk("R8 saved word", int'(status_word_o), 4'b1000);
    // R4: level 1, non-priority source is blocked
    drive(8'h08, 0, 0, 0, 0, '0, '0, '0, '0);
    chk("R4 blocked", int'(accept_o), 0);
    drive(8'h28, 0, 0, 0, 0, '0, '0, '0, 2'b01);
    chk("R4 prio passes", int'(accept_o), 1);
    chk("R3 level 2", int'(level_o), 2);
    // R5: level 2 holds everything
    drive(8'hFF, 0, 0, 0, 0, '0, '0, '0, '0);
    chk("R5 level2 hold", int'(accept_o), 0);
    // R11: write with gie on is ignored
    drive('0, 0, 0, 0, 0, '0, 2'b11, 2'b00, '0);
    chk("R11 ignored", int'(level_o), 2);
    // R9: return with requests pending; no accept, level restored to 1
    drive(8'hFF, 1, 0, 0, 0, '0, '0, '0, '0);
    chk("R9 no accept on ret", int'(accept_o), 0);
    chk("R9 restored", int'(level_o), 1);
    drive('0, 1, 0, 0, 0, '0, '0, '0, '0);
    chk("R9 restored 0", int'(level_o), 0);
    // R10: return on empty
    drive('0, 0, 1, 0, 0, '0, 2'b01, 2'b01, '0);   // gie off
    drive('0, 0, 0, 0, 0, '0, 2'b10, 2'b10, '0);   // level bit1 -> 1
    chk("R11 bit write", int'(level_o), 2);
    drive('0, 1, 0, 0, 0, '0, 2'b01, 2'b01, '0);   // ret beats write
    chk("R10 empty ret", int'(level_o), 0);
    chk("R10 no pop", int'(pop_o), 0);
    // R7: gie off blocks
    drive(8'h04, 0, 0, 0, 0, '0, '0, '0, '0);
    chk("R7 gie off", int'(accept_o), 0);
    // R12: five nested accepts of source 2 with level cleared in between
    for (int k = 0; k < 5; k++) begin
      drive('0, 0, 1, 1, 0, '0, '0, '0, '0);
      drive(8'h04, 0, 1, 0, 0, '0, '0, '0, 2'(k));
      chk("R2 nested accept", int'(accept_o), 1);
      drive('0, 0, 0, 0, 0, '0, 2'b11, 2'b00, '0);
      chk("R11 cleared", int'(level_o), 0);
    end
    chk("R12 overflow", int'(ovf_o), 1);
    drive('0, 1, 0, 0, 0, '0, '0, '0, '0);
    chk("R12 top kept", int'(status_word_o), {2'd3, 2'd0});
    chk("R12 sticky", int'(ovf_o), 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [N_SRC-1:0] rq;
      rq = ($urandom % 3 == 0) ? '0 : N_SRC'($urandom);
      drive(rq, ($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 3) != 0,
            ($urandom % 10) == 0, IDX_W'($urandom), 2'($urandom), 2'($urandom),
            FLAG_W'($urandom));
    end
    idle();

    $display("[TB] %0d tests run, %0d failed", tests, errs);
    $finish;
  end
endmodule